// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single-word bus requests into control sequences for an asynchronous DRAM. It splits a 24-bit byte address into a row part and a column part, and drives both parts one after the other on a shared multiplexed address bus. It also drives active-low RAS and CAS strobes. Requests use a valid/ready handshake. Refresh uses a request/acknowledge pair, and the refresh has priority over any access still waiting.

A static configuration sets five things:
- the multiplex shift (8, 9 or 10 bits),
- page-mode enable,
- RAS hold mode,
- the precharge length (one or two states),
- the number of wait states added to refresh (0 to 3).

When page mode and RAS hold are both on, the block keeps the last row open with RAS low. A later request to that same row then runs only a CAS phase. A request to any other row first closes the open row through precharge.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, ras_no and cas_no are 1, req_ready_o and rfsh_ack_o are 0, and the sequencer is idle with no open row.
- R2: cfg_shift_i codes 0, 1, 2 give a base shift s of 8, 9, 10; code 3 behaves like code 2. With b = bus16_i, the row word is addr >> (s+b) and the column word is addr[s+b-1:b], each driven on dram_addr_o.
- R3: A request hits the open row when addr[23:s+b] equals the same bits of the address that opened the row. So the compared range is 23..8/9/10 on an 8-bit bus and 23..9/10/11 on a 16-bit bus.
- R4: From the idle state, an access is full. One cycle has RAS low, CAS high and the row word out. The next cycle has RAS and CAS low and the column word out. req_ready_o is seen 2 cycles after req_valid_i is first sampled.
- R5: With cfg_burst_i=1 and cfg_ras_hold_i=1, a hit on the open row runs only a CAS cycle, with RAS still low. req_ready_o comes 1 cycle after the request.
- R6: Each precharge lasts 1 state when cfg_prech_i=0 and 2 states when cfg_prech_i=1. During precharge RAS and CAS are high.
- R7: RAS stays low after an access only when cfg_burst_i and cfg_ras_hold_i are both 1. Otherwise ras_no is 1 once the access ends.
- R8: A miss while a row is held raises RAS, runs the precharge states and then a full access. The latency is 2 plus the precharge length.
- R9: A refresh runs one cycle with CAS low and RAS high, then 1+cfg_rfsh_wait_i cycles with both low. rfsh_ack_o pulses in the last of those cycles.
- R10: A refresh while a row is held first precharges. After the refresh, no row is open, RAS is high, and the next access is full even to the same row.
- R11: req_ready_o is a one-cycle pulse. It is high only in the CAS cycle of an access, and the column word is on the bus in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_shift_i | input | 2 | Multiplex shift code |
| cfg_burst_i | input | 1 | Page-mode enable |
| cfg_ras_hold_i | input | 1 | Keep RAS low between accesses |
| cfg_prech_i | input | 1 | 0: one precharge state, 1: two |
| cfg_rfsh_wait_i | input | 2 | Refresh wait states |
| bus16_i | input | 1 | Space is 16 bits wide |
| req_valid_i | input | 1 | Access request |
| req_addr_i | input | 24 | Byte address, held with valid |
| req_ready_o | output | 1 | CAS phase done, access complete |
| rfsh_req_i | input | 1 | Refresh request, held until ack |
| rfsh_ack_o | output | 1 | Refresh done |
| dram_addr_o | output | 16 | Multiplexed row/column address |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |

## Verification
Access addresses come in three kinds:
- a repeat of the open row with only the column bits changed,
- a change in exactly the lowest compared bit,
- fully random values.

The first two kinds differ by one bit across the row/column boundary. Whether each access runs as a page hit (latency 1) or as a miss (latency 2 plus precharge) therefore shows where the compare range starts for every shift and bus width.

Every shift code and bus width is tried, together with both hold modes and both precharge lengths. This separates RAS-up release, RAS-down hold and the close-on-miss path.

Refresh is requested both from idle and with a row held, with each wait count. The acknowledge latency and the access after the refresh show that the refresh closes the row and invalidates it.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned MUX_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_PRE,
    ST_ROW,
    ST_CAS,
    ST_RF_CAS,
    ST_RF_RAS
  } seq_state_e;

  function automatic logic [4:0] base_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      default: return 5'd10;
    endcase
  endfunction
endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MW = MUX_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    shift_i,
  input  logic          bus16_i,
  output logic [AW-1:0] key_o,
  output logic [MW-1:0] row_o,
  output logic [MW-1:0] col_o
);
  logic [4:0]    base_sh;
  logic [4:0]    row_sh;
  logic [AW-1:0] col_mask;
  logic [AW-1:0] col_full;

  always_comb begin
    base_sh  = base_shift(shift_i);
    row_sh   = base_sh + {4'd0, bus16_i};
    key_o    = addr_i >> row_sh;
    col_mask = (AW'(1) << base_sh) - AW'(1);
    col_full = (addr_i >> bus16_i) & col_mask;
    row_o    = key_o[MW-1:0];
    col_o    = col_full[MW-1:0];
  end
endmodule

// File: rtl/dram_row_track.sv
module dram_row_track
  import dram_seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MW = MUX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    shift_i,
  input  logic          bus16_i,
  input  logic          latch_i,
  output logic          same_row_o,
  output logic [MW-1:0] row_o,
  output logic [MW-1:0] col_o
);
  localparam int unsigned NSRC = 2;

  logic [AW-1:0] lat_addr_q;
  logic [AW-1:0] src_addr [NSRC];
  logic [AW-1:0] src_key  [NSRC];
  logic [MW-1:0] src_row  [NSRC];
  logic [MW-1:0] src_col  [NSRC];

  assign src_addr[0] = req_addr_i;
  assign src_addr[1] = lat_addr_q;

  // slot 0: incoming request, slot 1: address of current/open access
  for (genvar g = 0; g < NSRC; g++) begin : g_mux
    dram_addr_mux #(.AW(AW), .MW(MW)) u_mux (
      .addr_i (src_addr[g]),
      .shift_i(shift_i),
      .bus16_i(bus16_i),
      .key_o  (src_key[g]),
      .row_o  (src_row[g]),
      .col_o  (src_col[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_addr_q <= '0;
    else if (latch_i) lat_addr_q <= req_addr_i;
  end

  assign same_row_o = (src_key[0] == src_key[1]);
  assign row_o      = src_row[1];
  assign col_o      = src_col[1];
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_burst_i,
  input  logic       cfg_ras_hold_i,
  input  logic       cfg_prech_i,
  input  logic [1:0] cfg_rfsh_wait_i,
  input  logic       req_valid_i,
  input  logic       same_row_i,
  input  logic       rfsh_req_i,
  output logic       latch_o,
  output logic       sel_col_o,
  output logic       ready_o,
  output logic       ack_o,
  output logic       ras_no,
  output logic       cas_no
);
  seq_state_e state_q, state_d, after_pre_q, after_pre_d;
  logic [1:0] cnt_q, cnt_d;
  logic       hold;
  logic       hit;

  assign hold = cfg_burst_i & cfg_ras_hold_i;
  assign hit  = hold & same_row_i;

  always_comb begin
    state_d     = state_q;
    after_pre_d = after_pre_q;
    cnt_d       = cnt_q;
    latch_o     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rfsh_req_i) begin
          state_d = ST_RF_CAS;
        end else if (req_valid_i) begin
          latch_o = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_OPEN: begin
        if (rfsh_req_i || !hold) begin
          state_d     = ST_PRE;
          after_pre_d = rfsh_req_i ? ST_RF_CAS : ST_IDLE;
          cnt_d       = {1'b0, cfg_prech_i};
        end else if (req_valid_i) begin
          latch_o = 1'b1;
          if (hit) begin
            state_d = ST_CAS;
          end else begin
            state_d     = ST_PRE;
            after_pre_d = ST_ROW;
            cnt_d       = {1'b0, cfg_prech_i};
          end
        end
      end
      ST_PRE: begin
        if (cnt_q == 2'd0) state_d = after_pre_q;
        else               cnt_d   = cnt_q - 2'd1;
      end
      ST_ROW: state_d = ST_CAS;
      ST_CAS: begin
        if (hold) begin
          state_d = ST_OPEN;
        end else begin
          state_d     = ST_PRE;
          after_pre_d = ST_IDLE;
          cnt_d       = {1'b0, cfg_prech_i};
        end
      end
      ST_RF_CAS: begin
        state_d = ST_RF_RAS;
        cnt_d   = cfg_rfsh_wait_i;
      end
      ST_RF_RAS: begin
        if (cnt_q == 2'd0) begin
          state_d     = ST_PRE;
          after_pre_d = ST_IDLE;
          cnt_d       = {1'b0, cfg_prech_i};
        end else begin
          cnt_d = cnt_q - 2'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      after_pre_q <= ST_IDLE;
      cnt_q       <= 2'd0;
    end else begin
      state_q     <= state_d;
      after_pre_q <= after_pre_d;
      cnt_q       <= cnt_d;
    end
  end

  always_comb begin
    ras_no    = !(state_q inside {ST_ROW, ST_CAS, ST_OPEN, ST_RF_RAS});
    cas_no    = !(state_q inside {ST_CAS, ST_RF_CAS, ST_RF_RAS});
    sel_col_o = (state_q == ST_CAS);
    ready_o   = (state_q == ST_CAS);
    ack_o     = (state_q == ST_RF_RAS) && (cnt_q == 2'd0);
  end

  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_ready_strobes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!ras_no && !cas_no && sel_col_o));
  p_cbr_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_no && ras_no) |=> (!cas_no && !ras_no));
  p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!ras_no && !cas_no) ##1 !ack_o);
  p_ras_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !hold) |=> ras_no);
  p_miss_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && req_valid_i && !rfsh_req_i && hold && !same_row_i) |=> (ras_no && cas_no));
  p_hit_fast_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && req_valid_i && !rfsh_req_i && hit) |=> ready_o);
  p_pre_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_no) && !cfg_prech_i) |=> (state_q != ST_PRE));
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MW = MUX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_shift_i,
  input  logic          cfg_burst_i,
  input  logic          cfg_ras_hold_i,
  input  logic          cfg_prech_i,
  input  logic [1:0]    cfg_rfsh_wait_i,
  input  logic          bus16_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  input  logic          rfsh_req_i,
  output logic          rfsh_ack_o,
  output logic [MW-1:0] dram_addr_o,
  output logic          ras_no,
  output logic          cas_no
);
  logic          latch;
  logic          same_row;
  logic          sel_col;
  logic [MW-1:0] row_w;
  logic [MW-1:0] col_w;

  dram_row_track #(.AW(AW), .MW(MW)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_addr_i(req_addr_i),
    .shift_i   (cfg_shift_i),
    .bus16_i   (bus16_i),
    .latch_i   (latch),
    .same_row_o(same_row),
    .row_o     (row_w),
    .col_o     (col_w)
  );

  dram_seq_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_burst_i    (cfg_burst_i),
    .cfg_ras_hold_i (cfg_ras_hold_i),
    .cfg_prech_i    (cfg_prech_i),
    .cfg_rfsh_wait_i(cfg_rfsh_wait_i),
    .req_valid_i    (req_valid_i),
    .same_row_i     (same_row),
    .rfsh_req_i     (rfsh_req_i),
    .latch_o        (latch),
    .sel_col_o      (sel_col),
    .ready_o        (req_ready_o),
    .ack_o          (rfsh_ack_o),
    .ras_no         (ras_no),
    .cas_no         (cas_no)
  );

  assign dram_addr_o = sel_col ? col_w : row_w;

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ras_no && cas_no && !req_ready_o));
  p_col_on_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (dram_addr_o == col_w));
endmodule

// File: tb/tb_dram_page_seq.sv
module tb_dram_page_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  shift = 2'd0;
  logic        burst = 1'b0, hold = 1'b0, prech = 1'b0, b16 = 1'b0;
  logic [1:0]  rwait = 2'd0;
  logic        valid = 1'b0, rfsh = 1'b0;
  logic [23:0] addr = '0;
  logic        ready, ack, ras_n, cas_n;
  logic [15:0] maddr;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit          m_open = 0;
  logic [23:0] m_addr = '0;

  always #4 clk = ~clk;

  dram_page_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_shift_i(shift), .cfg_burst_i(burst),
    .cfg_ras_hold_i(hold), .cfg_prech_i(prech), .cfg_rfsh_wait_i(rwait),
    .bus16_i(b16), .req_valid_i(valid), .req_addr_i(addr), .req_ready_o(ready),
    .rfsh_req_i(rfsh), .rfsh_ack_o(ack), .dram_addr_o(maddr),
    .ras_no(ras_n), .cas_no(cas_n)
  );

  function automatic int sh_of(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 9 : 10;
  endfunction
  function automatic logic [15:0] exp_row(input logic [23:0] a);
    logic [23:0] t = a >> (sh_of(shift) + int'(b16));
    return t[15:0];
  endfunction
  function automatic logic [15:0] exp_col(input logic [23:0] a);
    logic [23:0] t = '0;
    for (int i = 0; i < sh_of(shift); i++) t[i] = a[i + int'(b16)];
    return t[15:0];
  endfunction
  function automatic bit same_row(input logic [23:0] a, input logic [23:0] b);
    for (int i = sh_of(shift) + int'(b16); i < 24; i++)
      if (a[i] != b[i]) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic access(input logic [23:0] a);
    int lat = 0, exp_lat, p;
    bit hit;
    logic [15:0] prev_addr = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    p = prech ? 2 : 1;
    hit = m_open && same_row(a, m_addr);
    exp_lat = hit ? 1 : (m_open ? 2 + p : 2);
    addr = a; valid = 1'b1;
    while (!ready && lat < 20) begin
      prev_addr = maddr; prev_ras = ras_n; prev_cas = cas_n;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    chk(lat == exp_lat, hit ? "R5/R3 hit latency" : (m_open ? "R8/R6 miss latency" : "R4 full latency"),
        lat, exp_lat);
    chk(!ras_n && !cas_n, "R11 strobes at ready", {ras_n, cas_n}, 0);
    chk(maddr == exp_col(a), "R2 column word", maddr, exp_col(a));
    if (!hit) begin
      chk(!prev_ras && prev_cas, "R4 row phase strobes", {prev_ras, prev_cas}, 2'b01);
      chk(prev_addr == exp_row(a), "R2 row word", prev_addr, exp_row(a));
    end else begin
      chk(!prev_ras, "R5 RAS held through hit", prev_ras, 0);
    end
    valid = 1'b0;
    @(negedge clk);
    chk(!ready, "R11 single pulse", ready, 0);
    idle(3);
    m_open = burst && hold;
    m_addr = a;
    chk(ras_n == !m_open, "R7 RAS after access", ras_n, !m_open);
  endtask

  task automatic refresh();
    int lat = 0, exp_lat, p;
    bit saw_cbr = 0;
    p = prech ? 2 : 1;
    exp_lat = 2 + int'(rwait) + (m_open ? p : 0);
    rfsh = 1'b1;
    while (!ack && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!cas_n && ras_n) saw_cbr = 1;
    end
    chk(lat == exp_lat, m_open ? "R10 refresh latency from open row" : "R9 refresh latency",
        lat, exp_lat);
    chk(saw_cbr, "R9 CAS before RAS", saw_cbr, 1);
    chk(!ras_n && !cas_n, "R9 strobes at ack", {ras_n, cas_n}, 0);
    rfsh = 1'b0;
    idle(4);
    chk(ras_n && cas_n, "R10 row closed after refresh", {ras_n, cas_n}, 2'b11);
    m_open = 0;
  endtask

  initial begin
    logic [23:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !ready && !ack, "R1 reset state", {ras_n, cas_n, ready, ack}, 4'b1100);
    rst_n = 1'b1;
    idle(2);
    chk(ras_n && cas_n, "R1 idle after reset", {ras_n, cas_n}, 2'b11);
    // reset config: full accesses only, second one to same row still full
    access(24'h123456);
    access(24'h123457);
    // directed boundaries for every shift and width, with hold
    for (int c = 0; c < 4; c++) begin
      for (int w = 0; w < 2; w++) begin
        shift = c[1:0]; b16 = w[0]; burst = 1; hold = 1; prech = c[0];
        a = 24'hA5C3F1 ^ 24'(c * 24'h010101);
        access(a);
        access(a ^ (24'h1 << (sh_of(shift) + w - 1)));   // last column bit: hit
        access(a ^ (24'h1 << (sh_of(shift) + w)));       // lowest row bit: miss
        rwait = 2'(c);
        refresh();                                        // refresh from open row
        access(a ^ (24'h1 << (sh_of(shift) + w)));       // same row but full
      end
    end
    // constrained random
    for (int ph = 0; ph < 24; ph++) begin
      refresh();
      shift = 2'($urandom_range(0, 3)); b16 = 1'($urandom);
      burst = 1'($urandom); hold = 1'($urandom); prech = 1'($urandom);
      rwait = 2'($urandom_range(0, 3));
      for (int k = 0; k < 10; k++) begin
        case ($urandom_range(0, 3))
          0: a = 24'($urandom);
          1: a = m_addr ^ (24'h1 << (sh_of(shift) + int'(b16)));
          default: a = m_addr ^ 24'($urandom_range(0, (1 << (sh_of(shift) + int'(b16))) - 1));
        endcase
        access(a);
        if ($urandom_range(0, 7) == 0) refresh();
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule